// File: doc/BRIEF.md
# Multichannel Glitch-Free Pulse-Width Modulator

This block produces several independent pulse-width modulated outputs from one input clock. Each channel has a programmable divider, a tick counter that wraps at a programmed length, and a compare window that marks an "active" phase inside each period. The output level in the active phase and the level in the idle phase are programmed separately, so either polarity is available. Software programs the channels through a small word-addressed register file. Every register can be written directly, or through aliases that OR, clear or XOR the written bits into it.

Each channel keeps two software-visible shadow words. One is the compare word, which holds the window bounds. The other is the timing word, which holds the length, the divider code and the two level codes. The running channel works from private copies of these words. Writing the timing word arms a pending load. The copies are refreshed only when the current period ends, so a running output never shows a truncated or mixed period. A channel that is switched off takes the shadow values at once. It holds its counter at zero and drives its idle level.

Top module: `shadow_pwm`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: Word address bits [3:2] select the write action on the addressed register: 0 stores the data, 1 ORs the data in, 2 clears the bits that are set in the data, and 3 inverts those bits. A read returns the stored value at any of the four aliases.
- R3: The enable register is at byte offset 0x00, and bit n of it runs channel n. Channel n has its compare word at byte offset 0x10 + 0x20·n and its timing word at byte offset 0x20 + 0x20·n.
- R4: A running channel repeats a period of L ticks, where L is timing bits [15:0]. The tick counter runs from 0 to L−1. The active phase covers the ticks with S ≤ count < E, where S is compare bits [15:0] and E is compare bits [31:16].
- R5: Timing bits [22:20] choose the tick length in input clocks. The codes 0, 1, 2, 3, 4, 5, 6 and 7 give 1, 2, 4, 8, 16, 64, 256 and 1024 clocks.
- R6: Timing bits [17:16] give the level during the active phase and bits [19:18] give the level during the idle phase. The code 2'b11 drives high and any other code drives low.
- R7: A write to the compare word alone does not change a running output. Only a later write to the timing word arms the load of both words.
- R8: An armed load is applied only at the end of the period that is in progress, so the rest of that period keeps the old settings.
- R9: A disabled channel holds its counter at zero and drives its idle level. It takes an armed load at once, and when it is enabled it starts a new period at count 0.
- R10: When E ≤ S the output stays at the idle level. When E ≥ L and S = 0 the output stays at the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock shared by all channels |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1 down to 2) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for the addressed register |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit byte address. Short periods of five to ten ticks keep every prescaler code, including the 1024-clock divider, within a few thousand clocks per measurement, so all eight codes are swept on one channel and their high and low times are checked against arithmetic expectations. The other channels cover the inverted level codes and the write aliases. They also cover a compare-only write, the degenerate window bounds, and a reprogram that lands in the middle of a period, with the transition timed cycle by cycle.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 10;
  localparam int PER_W  = 23;

  localparam int ACT_LVL_LSB  = 16;
  localparam int IDLE_LVL_LSB = 18;
  localparam int CDIV_LSB     = 20;
  localparam int END_LSB      = 16;

  localparam logic [1:0] LVL_HIGH = 2'b11;

  typedef struct packed {
    logic run;
    logic load;
  } chStrobe_t;

  function automatic logic [3:0] prescaleShift(input logic [2:0] code);
    case (code)
      3'd5:    prescaleShift = 4'd6;
      3'd6:    prescaleShift = 4'd8;
      3'd7:    prescaleShift = 4'd10;
      default: prescaleShift = {1'b0, code};
    endcase
  endfunction
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:2]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  input  logic [NUM_CH-1:0]              boundary,
  output chStrobe_t [NUM_CH-1:0]         strobes,
  output logic [NUM_CH-1:0][DATA_W-1:0]  shadowAct,
  output logic [NUM_CH-1:0][DATA_W-1:0]  shadowPer,
  output logic [NUM_CH-1:0]              ctrlQ,
  output logic [NUM_CH-1:0]              pendQ
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] regIdx;
  logic [1:0]       aliasSel;
  logic             hitCtrl;
  logic [NUM_CH-1:0] hitAct, hitPer;
  logic [NUM_CH-1:0] ctrlNext;

  assign regIdx   = addr[ADDR_W-1:4];
  assign aliasSel = addr[3:2];
  assign hitCtrl  = (regIdx == '0);

  function automatic logic [DATA_W-1:0] aliasWord(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] d,
                                                  input logic [1:0]        sel);
    case (sel)
      2'd0:    aliasWord = d;
      2'd1:    aliasWord = old | d;
      2'd2:    aliasWord = old & ~d;
      default: aliasWord = old ^ d;
    endcase
  endfunction

  always_comb begin
    case (aliasSel)
      2'd0:    ctrlNext = wrData[NUM_CH-1:0];
      2'd1:    ctrlNext = ctrlQ | wrData[NUM_CH-1:0];
      2'd2:    ctrlNext = ctrlQ & ~wrData[NUM_CH-1:0];
      default: ctrlNext = ctrlQ ^ wrData[NUM_CH-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ctrlQ <= '0;
    else if (wrEn && hitCtrl) ctrlQ <= ctrlNext;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chReg
    assign hitAct[i] = (regIdx == IDX_W'(2 * i + 1));
    assign hitPer[i] = (regIdx == IDX_W'(2 * i + 2));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowAct[i] <= '0;
        shadowPer[i] <= '0;
        pendQ[i]     <= 1'b0;
      end else begin
        if (wrEn && hitAct[i]) shadowAct[i] <= aliasWord(shadowAct[i], wrData, aliasSel);
        if (wrEn && hitPer[i]) shadowPer[i] <= aliasWord(shadowPer[i], wrData, aliasSel);
        if (wrEn && hitPer[i])   pendQ[i] <= 1'b1;
        else if (strobes[i].load) pendQ[i] <= 1'b0;
      end
    end

    assign strobes[i].run  = ctrlQ[i];
    assign strobes[i].load = pendQ[i] && (boundary[i] || !ctrlQ[i]);
  end

  always_comb begin
    rdData = '0;
    if (hitCtrl) rdData = DATA_W'(ctrlQ);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hitAct[i]) rdData = shadowAct[i];
      if (hitPer[i]) rdData = shadowPer[i];
    end
  end
endmodule

// File: rtl/spwm_chan.sv
module spwm_chan
  import spwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe,
  input  logic [DATA_W-1:0] shadowAct,
  input  logic [PER_W-1:0]  shadowPer,
  output logic              boundary,
  output logic              pwmOut
);
  logic [PRE_W-1:0] preCnt, preMax;
  logic [CNT_W-1:0] cnt, workStart, workEnd, workLen;
  logic [2:0]       workCdiv;
  logic [1:0]       workActLvl, workIdleLvl;
  logic             tick, wrapEdge, inActive, activeHigh, idleHigh;

  assign preMax   = {PRE_W{1'b1}} >> (PRE_W - int'(prescaleShift(workCdiv)));
  assign tick     = (preCnt == preMax);
  assign wrapEdge = tick && (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, workLen});
  assign boundary = strobe.run && wrapEdge;

  assign inActive   = (cnt >= workStart) && (cnt < workEnd);
  assign activeHigh = (workActLvl == LVL_HIGH);
  assign idleHigh   = (workIdleLvl == LVL_HIGH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (!strobe.run) begin
      preCnt <= '0;
      cnt    <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) cnt <= wrapEdge ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workStart   <= '0;
      workEnd     <= '0;
      workLen     <= '0;
      workCdiv    <= '0;
      workActLvl  <= '0;
      workIdleLvl <= '0;
    end else if (strobe.load) begin
      workStart   <= shadowAct[CNT_W-1:0];
      workEnd     <= shadowAct[END_LSB +: CNT_W];
      workLen     <= shadowPer[CNT_W-1:0];
      workCdiv    <= shadowPer[CDIV_LSB +: 3];
      workActLvl  <= shadowPer[ACT_LVL_LSB +: 2];
      workIdleLvl <= shadowPer[IDLE_LVL_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pwmOut <= 1'b0;
    else if (strobe.run && inActive)  pwmOut <= activeHigh;
    else                              pwmOut <= idleHigh;
  end
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:2] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chStrobe_t [NUM_CH-1:0]         strobes;
  logic [NUM_CH-1:0][DATA_W-1:0]  shadowAct, shadowPer;
  logic [NUM_CH-1:0]              boundVec, ctrlQ, pendQ, runVec, loadVec;

  spwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .boundary(boundVec), .strobes(strobes),
    .shadowAct(shadowAct), .shadowPer(shadowPer), .ctrlQ(ctrlQ), .pendQ(pendQ)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign runVec[i]  = strobes[i].run;
    assign loadVec[i] = strobes[i].load;

    spwm_chan u_chan (
      .clk(clk), .rstN(rstN), .strobe(strobes[i]),
      .shadowAct(shadowAct[i]), .shadowPer(shadowPer[i][PER_W-1:0]),
      .boundary(boundVec[i]), .pwmOut(pwmOut[i])
    );
  end
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:2] addr,
  input logic [31:0]       wrData,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] ctrlQ,
  input logic [NUM_CH-1:0] pendQ,
  input logic [NUM_CH-1:0] runVec,
  input logic [NUM_CH-1:0] loadVec,
  input logic [NUM_CH-1:0] boundVec
);
  localparam int IDX_W = ADDR_W - 4;

  // R2: plain store into the enable register
  a_r2_plain_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0) |=> ctrlQ == $past(wrData[NUM_CH-1:0]));

  // R2: OR alias of the enable register
  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == (ADDR_W-2)'(1)) |=> ctrlQ == ($past(ctrlQ) | $past(wrData[NUM_CH-1:0])));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7: a timing-word write arms the pending load
    a_r7_timing_arms: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr[ADDR_W-1:4] == IDX_W'(2 * i + 2)) |=> pendQ[i]);

    // R8: a running channel loads only on its period boundary
    a_r8_load_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
      (loadVec[i] && runVec[i]) |-> boundVec[i]);

    // R9: a disabled channel without a load keeps its output steady
    a_r9_idle_steady: assert property (@(posedge clk) disable iff (!rstN)
      (!runVec[i] && !loadVec[i] && !$past(runVec[i]) && !$past(loadVec[i]))
        |=> $stable(pwmOut[i]));
  end
endmodule

bind shadow_pwm shadow_pwm_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .pwmOut(pwmOut), .ctrlQ(ctrlQ), .pendQ(pendQ), .runVec(runVec),
  .loadVec(loadVec), .boundVec(boundVec)
);

// File: tb/shadow_pwm_bench.sv
module shadow_pwm_bench;
  localparam int CLK_NS = 10;
  localparam int NCH    = 4;
  localparam int AW     = 8;
  localparam int LIMIT  = 30000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:2] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NCH-1:0] pwmOut;

  int nChecks = 0;
  int nFails  = 0;

  shadow_pwm #(.NUM_CH(NCH), .ADDR_W(AW)) u_shadow_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] actAddr(input int ch);
    return 32'(16 + 32 * ch);
  endfunction
  function automatic logic [31:0] perAddr(input int ch);
    return 32'(32 + 32 * ch);
  endfunction
  function automatic logic [31:0] perWord(input int len, input int code, input int actLvl, input int idleLvl);
    return 32'(len) | (32'(actLvl) << 16) | (32'(idleLvl) << 18) | (32'(code) << 20);
  endfunction
  function automatic int divOf(input int code);
    int sh;
    sh = (code <= 4) ? code : (code == 5 ? 6 : (code == 6 ? 8 : 10));
    return 1 << sh;
  endfunction

  task automatic busWrite(input logic [31:0] byteAddr, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = byteAddr[AW-1:2]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [31:0] byteAddr, output logic [31:0] d);
    @(negedge clk);
    addr = byteAddr[AW-1:2];
    #1 d = rdData;
  endtask

  task automatic syncRise(input int ch);
    int g = 0;
    @(negedge clk);
    while (pwmOut[ch] == 1'b1 && g < LIMIT) begin @(negedge clk); g++; end
    while (pwmOut[ch] == 1'b0 && g < LIMIT) begin @(negedge clk); g++; end
  endtask

  task automatic countHigh(input int ch, inout int n);
    while (pwmOut[ch] == 1'b1 && n < LIMIT) begin n++; @(negedge clk); end
  endtask
  task automatic countLow(input int ch, inout int n);
    while (pwmOut[ch] == 1'b0 && n < LIMIT) begin n++; @(negedge clk); end
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    syncRise(ch);
    hi = 0; countHigh(ch, hi);
    lo = 0; countLow(ch, lo);
  endtask

  task automatic steadyCount(input int ch, input int cycles, output int highs);
    highs = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pwmOut[ch]) highs++;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int hi, lo, n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk(pwmOut == '0, "R1 outputs low after reset", pwmOut, 0);
    busRead(32'h00, rd);
    chk(rd == 0, "R1 enable register zero", rd, 0);
    busRead(perAddr(2), rd);
    chk(rd == 0, "R1 timing word zero", rd, 0);

    // R5/R4: sweep every prescaler code on channel 0, L=5, E=2, normal levels
    busWrite(actAddr(0), 32'(2) << 16);
    busWrite(perAddr(0), perWord(5, 0, 3, 2));
    busWrite(32'h04, 32'h1);
    for (int code = 0; code < 8; code++) begin
      busWrite(actAddr(0), 32'(2) << 16);
      busWrite(perAddr(0), perWord(5, code, 3, 2));
      measure(0, hi, lo);
      measure(0, hi, lo);
      chk(hi == 2 * divOf(code), $sformatf("R5 high time code %0d", code), hi, 2 * divOf(code));
      chk(lo == 3 * divOf(code), $sformatf("R4 low time code %0d", code), lo, 3 * divOf(code));
    end

    // R9: disabled channel 1 takes inverted levels at once (idle level high)
    busWrite(actAddr(1), 32'(3) << 16);
    busWrite(perAddr(1), perWord(8, 1, 2, 3));
    repeat (3) @(negedge clk);
    chk(pwmOut[1] == 1'b1, "R9 disabled output shows new idle level", pwmOut[1], 1);

    // R3/R2: OR alias enables channel 1 beside channel 0
    busWrite(32'h04, 32'h2);
    busRead(32'h00, rd);
    chk(rd == 32'h3, "R2 OR alias of enable register", rd, 3);

    // R6: inverted levels, L=8 E=3 tick=2 clocks: high=idle 10, low=active 6
    measure(1, hi, lo);
    measure(1, hi, lo);
    chk(hi == 10, "R6 inverted idle-high time", hi, 10);
    chk(lo == 6, "R6 inverted active-low time", lo, 6);

    // R2/R9: XOR alias turns channel 1 off, it rests at its high idle level
    busWrite(32'h0C, 32'h2);
    busRead(32'h00, rd);
    chk(rd == 32'h1, "R2 XOR alias of enable register", rd, 1);
    repeat (2) @(negedge clk);
    steadyCount(1, 20, n);
    chk(n == 20, "R9 disabled channel held at idle level", n, 20);

    // R2/R9: clear alias turns channel 0 off, it rests low
    busWrite(32'h08, 32'h1);
    busRead(32'h00, rd);
    chk(rd == 32'h0, "R2 clear alias of enable register", rd, 0);
    repeat (2) @(negedge clk);
    steadyCount(0, 20, n);
    chk(n == 0, "R9 disabled normal channel low", n, 0);

    // R9: re-enable starts from count 0: pattern 1,1,0,0,0 with tick=1 clock
    busWrite(perAddr(0), perWord(5, 0, 3, 2));
    repeat (3) @(negedge clk);
    busWrite(32'h04, 32'h1);
    begin
      logic [4:0] pat;
      for (int k = 0; k < 5; k++) begin @(negedge clk); pat[4-k] = pwmOut[0]; end
      chk(pat == 5'b11000, "R9 enable restarts period at count 0", pat, 5'b11000);
    end

    // R7: compare-only write has no effect on running channel 2
    busWrite(actAddr(2), 32'(4) << 16);
    busWrite(perAddr(2), perWord(10, 0, 3, 2));
    busWrite(32'h04, 32'h4);
    measure(2, hi, lo);
    chk(hi == 4 && lo == 6, "R4 channel 2 base duty (high)", hi, 4);
    busWrite(actAddr(2), 32'(7) << 16);
    measure(2, hi, lo);
    measure(2, hi, lo);
    chk(hi == 4, "R7 compare-only write ignored (high)", hi, 4);
    chk(lo == 6, "R7 compare-only write ignored (low)", lo, 6);
    busWrite(perAddr(2), perWord(10, 0, 3, 2));
    measure(2, hi, lo);
    measure(2, hi, lo);
    chk(hi == 7 && lo == 3, "R7 timing write applies compare word (high)", hi, 7);

    // R4: nonzero window start, S=2 E=6 L=10
    busWrite(actAddr(2), (32'(6) << 16) | 32'd2);
    busWrite(perAddr(2), perWord(10, 0, 3, 2));
    measure(2, hi, lo);
    measure(2, hi, lo);
    chk(hi == 4, "R4 window start offset high time", hi, 4);
    chk(lo == 6, "R4 window start offset low time", lo, 6);

    // R10: empty window -> constant idle; end beyond length -> constant active
    busWrite(actAddr(2), 32'd0);
    busWrite(perAddr(2), perWord(10, 0, 3, 2));
    repeat (25) @(negedge clk);
    steadyCount(2, 30, n);
    chk(n == 0, "R10 empty window stays idle", n, 0);
    busWrite(actAddr(2), 32'(15) << 16);
    busWrite(perAddr(2), perWord(10, 0, 3, 2));
    repeat (25) @(negedge clk);
    steadyCount(2, 30, n);
    chk(n == 30, "R10 window past length stays active", n, 30);

    // R8: mid-period reprogram on channel 3, tick=4 clocks, L=10 E=5 -> L=6 E=2
    busWrite(actAddr(3), 32'(5) << 16);
    busWrite(perAddr(3), perWord(10, 2, 3, 2));
    busWrite(32'h04, 32'h8);
    measure(3, hi, lo);
    syncRise(3);
    busWrite(actAddr(3), 32'(2) << 16);
    busWrite(perAddr(3), perWord(6, 2, 3, 2));
    hi = 4; countHigh(3, hi);
    lo = 0; countLow(3, lo);
    chk(hi == 20, "R8 current period keeps old high time", hi, 20);
    chk(lo == 20, "R8 current period keeps old low time", lo, 20);
    hi = 0; countHigh(3, hi);
    lo = 0; countLow(3, lo);
    chk(hi == 8, "R8 next period new high time", hi, 8);
    chk(lo == 16, "R8 next period new low time", lo, 16);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule